// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a watchdog that raises its response one step per unserviced timeout. A free-running counter makes a periodic timeout event. The period is chosen by a 2-bit field in the control register. Two status flags record the escalation state: an arm flag and an interrupt-pending flag. On the first unserviced timeout the watchdog arms. On the next one it raises an interrupt. On the one after that it requests a reset of the type held in the control register.

Software services the watchdog through a small register port. It writes 1 to the arm flag to clear it after each successful health check. Once software has given the reset-type field a non-zero value, software can no longer clear it. Only a fired reset clears the field, and the fired type is kept in a read-only status field. The reset request is a one-cycle pulse with a type code. Whatever is outside this block carries out the reset. That reset never touches this block's own state: only the power-on reset input `rst_ni` clears it.

Top module: `wdog_escalate`

## Requirements
- R1: The timeout event fires in the cycle where the selected counter tap goes from 0 to 1. Period field 0, 1, 2 and 3 select counter bits 3, 5, 7 and 9, which gives periods of 16, 64, 256 and 1024 cycles. The counter starts at zero on power-on reset, so with field 0 the arm flag first reads 1 after the 9th clock edge. Changing the period field does not by itself make an event.
- R2: On a timeout event the flags change as follows:
  - If the arm flag is clear, the arm flag is set, whatever the pending flag holds.
  - If the arm flag is set and the pending flag is clear, the pending flag is set.
  - If both flags are set, neither flag changes.
  
  Each update is visible one edge after the event. Both flags are 0 after power-on reset.
- R3: A write to the status register clears the arm flag when data bit 0 is 1 and the pending flag when data bit 1 is 1. A data bit of 0 leaves its flag alone. A clear in the same cycle as a timeout event acts first, and the event then acts on the cleared flags.
- R4: `irq_o` is 1 exactly when all three of these hold: the pending flag is set, the interrupt enable bit is 1, and `crit_en_i` is 1. It follows these inputs in the same cycle.
- R5: A timeout event with both flags set and a non-zero reset-type field makes `rst_req_o` high for exactly one cycle, starting one edge after the event. During that pulse `rst_kind_o` carries the field value: 01 core, 10 chip, 11 system. At every other time `rst_kind_o` is 00. With the field at 00, no pulse is made.
- R6: When the reset fires, the reset-type value from before the reset is copied into the reset-status field, and the reset-type field becomes 00. Both changes happen at the same edge on which the pulse starts.
- R7: While the reset-type field is non-zero, software writes leave it unchanged. While it is 00, a control write loads it. A reset firing in the same cycle wins over a write.
- R8: The register map is as follows. Addresses 2 and 3 read as 0 and ignore writes. All registers read as 0 after power-on reset.

  | Address | Register | Bit 0 | Bits 2:1 | Bits 3:2 | Bits 4:3 | Unlisted bits |
  |---------|----------|-------|----------|----------|----------|---------------|
  | 0 | Control (read/write) | interrupt enable | reset type | | period | read 0 |
  | 1 | Status | arm flag | | reset status (read-only) | | read 0 |

  In the status register, bit 1 is the pending flag.
- R9: If the arm flag is cleared at least once in every timeout period, the pending flag never sets. After the last clear, the pending flag sets no sooner than one period and no later than two periods later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| crit_en_i | input | 1 | External critical-interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_kind_o | output | 2 | Reset type during the request, 00 otherwise |

## Verification
Read data and `irq_o` follow the current address and state in the same cycle. The flags, the control and status fields, and the reset pulse all change one edge after the cycle that causes them. The timeout event is itself one cycle behind the counter value that produces it. The bench keeps a cycle model that it advances once per clock edge, using the inputs it drove for that edge. It compares every output with the model at the falling edge that follows. Directed checks count edges from the release of reset or from the last service, and they sample at that same falling-edge point.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned N_TAPS = 4;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    RK_NONE   = 2'b00,
    RK_CORE   = 2'b01,
    RK_CHIP   = 2'b10,
    RK_SYSTEM = 2'b11
  } rst_kind_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;

  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_RC_LSB  = 1;
  localparam int unsigned CTL_SEL_LSB = 3;
  localparam int unsigned ST_ARM_BIT  = 0;
  localparam int unsigned ST_PEND_BIT = 1;
  localparam int unsigned ST_RS_LSB   = 2;
  localparam int unsigned USED_BITS   = 5;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick
  import wdog_pkg::*;
#(
  parameter int unsigned TAP_BASE = 3,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned TOP_BIT = TAP_BASE + (N_TAPS - 1) * TAP_STEP;
  localparam int unsigned CNT_W   = TOP_BIT + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [N_TAPS-1:0] tap_now, tap_q, rise;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign tap_now[g] = cnt_q[TAP_BASE + g * TAP_STEP];
  end

  // per-tap edge detect: a period change never fakes an edge
  assign rise   = tap_now & ~tap_q;
  assign tick_o = rise[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tap_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tap_q <= tap_now;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_irq_en_i,
  input  rst_kind_e        wr_rc_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             fire_i,
  output logic             irq_en_o,
  output logic [SEL_W-1:0] sel_o,
  output rst_kind_e        rst_ctl_o,
  output rst_kind_e        rst_stat_o
);
  logic             irq_en_q;
  logic [SEL_W-1:0] sel_q;
  rst_kind_e        ctl_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      sel_q    <= '0;
      ctl_q    <= RK_NONE;
      stat_q   <= RK_NONE;
    end else begin
      if (wr_i) begin
        irq_en_q <= wr_irq_en_i;
        sel_q    <= wr_sel_i;
      end
      if (fire_i) begin
        stat_q <= ctl_q;
        ctl_q  <= RK_NONE;
      end else if (wr_i && ctl_q == RK_NONE) begin
        ctl_q <= wr_rc_i;  // sticky: loads only from zero
      end
    end
  end

  assign irq_en_o   = irq_en_q;
  assign sel_o      = sel_q;
  assign rst_ctl_o  = ctl_q;
  assign rst_stat_o = stat_q;
endmodule

// File: rtl/wdog_status.sv
module wdog_status
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      clr_arm_i,
  input  logic      clr_pend_i,
  input  rst_kind_e rst_ctl_i,
  output logic      arm_o,
  output logic      pend_o,
  output logic      fire_o,
  output logic      rst_req_o,
  output rst_kind_e rst_kind_o
);
  logic      arm_q, pend_q, arm_c, pend_c, arm_n, pend_n, fire;
  logic      req_q;
  rst_kind_e kind_q;

  always_comb begin
    // clear first, then the event sees the cleared flags
    arm_c  = arm_q & ~clr_arm_i;
    pend_c = pend_q & ~clr_pend_i;
    arm_n  = arm_c;
    pend_n = pend_c;
    fire   = 1'b0;
    if (tick_i) begin
      unique case ({arm_c, pend_c})
        2'b00, 2'b01: arm_n  = 1'b1;
        2'b10:        pend_n = 1'b1;
        default:      fire   = (rst_ctl_i != RK_NONE);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= RK_NONE;
    end else begin
      arm_q  <= arm_n;
      pend_q <= pend_n;
      req_q  <= fire;
      kind_q <= fire ? rst_ctl_i : RK_NONE;
    end
  end

  assign arm_o      = arm_q;
  assign pend_o     = pend_q;
  assign fire_o     = fire;
  assign rst_req_o  = req_q;
  assign rst_kind_o = kind_q;
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int unsigned TAP_BASE = 3,
  parameter int unsigned TAP_STEP = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crit_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [1:0]        rst_kind_o
);
  logic             sel_ctrl, sel_stat;
  logic             irq_en_q, arm_q, pend_q, tick, fire;
  logic [SEL_W-1:0] period_q;
  rst_kind_e        rst_ctl_q, rst_stat_q, kind_q;
  logic             unused_wdata;

  assign sel_ctrl     = (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_stat     = (reg_addr_i == ADDR_W'(ADDR_STAT));
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:USED_BITS];

  wdog_tick #(
    .TAP_BASE (TAP_BASE),
    .TAP_STEP (TAP_STEP)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (period_q),
    .tick_o (tick)
  );

  wdog_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_we_i & sel_ctrl),
    .wr_irq_en_i (reg_wdata_i[CTL_EN_BIT]),
    .wr_rc_i     (rst_kind_e'(reg_wdata_i[CTL_RC_LSB +: 2])),
    .wr_sel_i    (reg_wdata_i[CTL_SEL_LSB +: SEL_W]),
    .fire_i      (fire),
    .irq_en_o    (irq_en_q),
    .sel_o       (period_q),
    .rst_ctl_o   (rst_ctl_q),
    .rst_stat_o  (rst_stat_q)
  );

  wdog_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clr_arm_i  (reg_we_i & sel_stat & reg_wdata_i[ST_ARM_BIT]),
    .clr_pend_i (reg_we_i & sel_stat & reg_wdata_i[ST_PEND_BIT]),
    .rst_ctl_i  (rst_ctl_q),
    .arm_o      (arm_q),
    .pend_o     (pend_q),
    .fire_o     (fire),
    .rst_req_o  (rst_req_o),
    .rst_kind_o (kind_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) begin
      reg_rdata_o[CTL_EN_BIT]             = irq_en_q;
      reg_rdata_o[CTL_RC_LSB +: 2]        = rst_ctl_q;
      reg_rdata_o[CTL_SEL_LSB +: SEL_W]   = period_q;
    end else if (sel_stat) begin
      reg_rdata_o[ST_ARM_BIT]             = arm_q;
      reg_rdata_o[ST_PEND_BIT]            = pend_q;
      reg_rdata_o[ST_RS_LSB +: 2]         = rst_stat_q;
    end
  end

  assign irq_o      = pend_q & irq_en_q & crit_en_i;
  assign rst_kind_o = kind_q;
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       crit_en_i,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic [1:0] rst_kind_o,
  input logic       arm_i,
  input logic       pend_i,
  input logic [1:0] ctl_i,
  input logic [1:0] stat_i
);
  assert_pend_after_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i) |-> arm_i);

  assert_irq_needs_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_i && crit_en_i));

  assert_req_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_kind_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_kind_o != 2'b00));

  assert_kind_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o |-> (rst_kind_o == 2'b00));

  assert_fire_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (ctl_i == 2'b00 && stat_i == rst_kind_o));

  assert_ctl_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctl_i) != 2'b00 && ctl_i != $past(ctl_i)) |-> rst_req_o);
endmodule

bind wdog_escalate wdog_escalate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .crit_en_i  (crit_en_i),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .rst_kind_o (rst_kind_o),
  .arm_i      (arm_q),
  .pend_i     (pend_q),
  .ctl_i      (rst_ctl_q),
  .stat_i     (rst_stat_q)
);

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       crit_en = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, req;
  logic [1:0] kind;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_escalate u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .crit_en_i   (crit_en),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .rst_req_o   (req),
    .rst_kind_o  (kind)
  );

  // cycle model built from the requirements
  logic [9:0] m_cnt;
  logic [3:0] m_prev;
  logic       m_arm, m_pend, m_en, m_req;
  logic [1:0] m_sel, m_ctl, m_stat, m_kind;

  task automatic model_init();
    m_cnt = '0; m_prev = '0; m_arm = 0; m_pend = 0; m_en = 0; m_req = 0;
    m_sel = '0; m_ctl = '0; m_stat = '0; m_kind = '0;
  endtask

  task automatic model_step(input logic w, input logic [1:0] a, input logic [7:0] d);
    logic [3:0] tn;
    logic tk, ac, pc, na, np, fire;
    for (int k = 0; k < 4; k++) tn[k] = m_cnt[3 + 2 * k];
    tk = tn[m_sel] & ~m_prev[m_sel];
    ac = m_arm & ~(w && a == 2'd1 && d[0]);
    pc = m_pend & ~(w && a == 2'd1 && d[1]);
    na = ac; np = pc; fire = 0;
    if (tk) begin
      if (!ac) na = 1;
      else if (!pc) np = 1;
      else fire = (m_ctl != 2'b00);
    end
    m_req  = fire;
    m_kind = fire ? m_ctl : 2'b00;
    if (fire) begin
      m_stat = m_ctl;
      m_ctl  = 2'b00;
    end else if (w && a == 2'd0 && m_ctl == 2'b00) begin
      m_ctl = d[2:1];
    end
    if (w && a == 2'd0) begin
      m_en  = d[0];
      m_sel = d[4:3];
    end
    m_arm = na; m_pend = np;
    m_cnt = m_cnt + 1'b1;
    m_prev = tn;
  endtask

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    if (a == 2'd0) return {3'b0, m_sel, m_ctl, m_en};
    if (a == 2'd1) return {4'b0, m_stat, m_pend, m_arm};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d);
    we = w; addr = a; wdata = d;
    model_step(w, a, d);
    @(negedge clk);
    check("R4", "irq", irq, m_pend & m_en & crit_en);
    check("R5", "rst_req", req, m_req);
    check("R5", "rst_kind", kind, m_kind);
    if (a == 2'd0)      check("R7", "ctrl read", rdata, exp_rdata(a));
    else if (a == 2'd1) check("R2", "status read", rdata, exp_rdata(a));
    else                check("R8", "unmapped read", rdata, exp_rdata(a));
  endtask

  initial begin
    int n;
    bit seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    model_init();
    check("R8", "reset ctrl", rdata, 0);
    check("R4", "reset irq", irq, 0);
    check("R5", "reset req", req, 0);

    // R1: first arm after 9 edges with period 0
    repeat (8) cyc(0, 2'd1, 8'h00);
    check("R1", "arm before 9th edge", rdata[0], 0);
    cyc(0, 2'd1, 8'h00);
    check("R1", "arm at 9th edge", rdata[0], 1);

    // R2: next event sets pending
    repeat (16) cyc(0, 2'd1, 8'h00);
    check("R2", "pending set", rdata[1], 1);

    // R3: write-one-to-clear, zero bits untouched
    cyc(1, 2'd1, 8'h02);
    check("R3", "clear pend only", rdata[1:0], 2'b01);
    cyc(1, 2'd1, 8'h01);
    check("R3", "clear arm", rdata[1:0], 2'b00);

    // R5/R6: core reset fires after escalation
    cyc(1, 2'd0, 8'h03);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      cyc(0, 2'd1, 8'h00);
      if (req) begin
        seen = 1;
        check("R5", "kind core", kind, 1);
        check("R6", "status copy", rdata[3:2], 1);
      end
    end
    check("R5", "reset pulse seen", seen, 1);
    cyc(0, 2'd0, 8'h00);
    check("R6", "ctl cleared", rdata[2:1], 0);

    // R4: gate by external enable
    crit_en = 1'b0;
    cyc(0, 2'd1, 8'h00);
    check("R4", "irq masked", irq, 0);
    crit_en = 1'b1;
    cyc(0, 2'd1, 8'h00);
    check("R4", "irq on", irq, 1);

    // R7: sticky reset type
    cyc(1, 2'd0, 8'h05);
    cyc(1, 2'd0, 8'h01);
    check("R7", "no clear by write", rdata[2:1], 2);
    cyc(1, 2'd0, 8'h07);
    check("R7", "no change by write", rdata[2:1], 2);

    // R8: unmapped addresses
    cyc(1, 2'd2, 8'hFF);
    check("R8", "addr 2 reads zero", rdata, 0);
    cyc(1, 2'd3, 8'hFF);
    cyc(0, 2'd0, 8'h00);
    check("R8", "ctrl kept", rdata, 8'h05);

    // R9: periodic service keeps pending clear
    cyc(1, 2'd1, 8'h03);
    for (int p = 0; p < 60; p++) begin
      repeat (11) cyc(0, 2'd1, 8'h00);
      cyc(1, 2'd1, 8'h01);
    end
    check("R9", "pending while serviced", rdata[1], 0);
    n = 0;
    for (int i = 0; i < 100 && rdata[1] == 1'b0; i++) begin
      cyc(0, 2'd1, 8'h00);
      n++;
    end
    check("R9", "min window", (n >= 16) ? 1 : 0, 1);
    check("R9", "max window", (n <= 32) ? 1 : 0, 1);

    // R1: period change makes no event on its own
    cyc(1, 2'd1, 8'h03);
    cyc(1, 2'd0, 8'h1D);
    repeat (3) cyc(0, 2'd1, 8'h00);
    check("R1", "no event on period change", rdata[0], exp_rdata(2'd1) & 8'h01);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      logic w;
      logic [1:0] a;
      logic [7:0] d;
      w = ($urandom % 20) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      if (a == 2'd0 && ($urandom % 8) != 0) d[4:3] = 2'b00;
      if (($urandom % 50) == 0) crit_en = ~crit_en;
      cyc(w, a, d);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired for R1 to completion: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule